// File: doc/BRIEF.md
# UART Receive FIFO Control with Selectable 64-Byte Depth

This block is the FIFO control and receive-trigger part of a 16550-style UART. Software writes a FIFO control byte through a small register port. That byte turns the FIFOs on or off, clears the receive and transmit queues, and picks one of four receive trigger levels. A further bit widens the receive queue from 16 to 64 entries, and the same two trigger-select bits then map to a coarser set of levels. The receiver shifter pushes finished bytes into the queue. The host pops them from a separate port. The block raises a receive-data-available interrupt while the fill level is at or above the selected trigger.

The interrupt identification byte reports the FIFO state in its top three bits: the two highest bits are set while the FIFOs are on, and the next bit is set only in wide mode. Software can therefore probe for the wide queue by enabling it and reading back the pattern 111. The wide bit is only taken while the line control byte is zero, so the probe needs no divisor-latch access. A byte that arrives while the queue is full is dropped and recorded in a sticky overrun flag. Reading the status byte clears that flag.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the FIFOs are off, the fill level is 0, the interrupt is low, the identification byte (address 2) reads 8'h01 and the line control byte (address 3) reads 0.
- R2: A control write to address 2 with bit 0 set and bit 5 clear enables the FIFOs with 16 entries. The identification byte then reads bits 7:5 as 3'b110.
- R3: A control write with bits 0 and 5 both set, made while the line control byte is 0, selects 64 entries. The identification byte then reads bits 7:5 as 3'b111.
- R4: While the line control byte is nonzero, bit 5 of a control write leaves the width unchanged. A control write with bit 0 clear always turns the FIFOs off and clears wide mode.
- R5: In 16-entry mode, control bits 7:6 select a trigger of 1, 4, 8 or 14 bytes for codes 00, 01, 10 and 11.
- R6: In 64-entry mode, control bits 7:6 select a trigger of 1, 16, 32 or 56 bytes for codes 00, 01, 10 and 11.
- R7: The interrupt is high exactly while the fill level is at or above the trigger. Identification bits 3:0 read 4'b0100 while it is high and 4'b0001 while it is low.
- R8: With the FIFOs off, the queue holds one byte and the interrupt rises at one byte.
- R9: A push into a full queue without a pop in the same cycle is discarded and sets an overrun flag. The flag reads as bit 1 of address 5, where bit 0 shows a non-empty queue. A read of address 5 clears the flag unless a new overrun occurs in the same cycle.
- R10: Control bit 1 empties the receive queue. Control bit 2 gives a one-cycle pulse on tx_clear. Neither bit is stored, so a later control write without them clears nothing.
- R11: A control write that changes the enable state or the width empties the receive queue and pulses tx_clear.
- R12: Pops return bytes in push order. A pop of an empty queue is ignored. A push and a pop in the same cycle on a full queue are both accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears overrun at address 5) |
| reg_addr | input | 3 | Register address: 2 control/identification, 3 line control, 5 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| rx_push | input | 1 | Byte push from the receiver shifter |
| rx_byte | input | 8 | Byte being pushed |
| host_pop | input | 1 | Host pop request |
| host_byte | output | 8 | Oldest byte in the queue |
| rx_level | output | 7 | Receive queue fill level |
| rx_irq | output | 1 | Receive-data-available interrupt |
| tx_clear | output | 1 | One-cycle request to empty the transmit queue |

## Verification
Fill level, interrupt, identification byte and head byte all settle at the first clock edge after the push, pop or control write that moves them, because they come straight from registers. tx_clear is high during the single cycle that follows the edge of the control write. Read data and host_byte are combinational, so a status read reports the overrun flag as it stood before that edge. The bench drives every input just after a falling edge and compares all outputs against its own queue model 1 ns later. It then lets the model take the same rising edge as the design, which keeps each comparison aligned to the cycle in which the result is due.

// File: rtl/ufc_pkg.sv
// Shared constants for the UART FIFO control block: control-byte bit
// positions, register addresses, identification codes and trigger levels.
package ufc_pkg;
    localparam int FCR_EN    = 0;
    localparam int FCR_RXCLR = 1;
    localparam int FCR_TXCLR = 2;
    localparam int FCR_WIDE  = 5;
    localparam int FCR_TRIG  = 6;

    localparam logic [2:0] A_FCR_IIR = 3'd2;
    localparam logic [2:0] A_LCR     = 3'd3;
    localparam logic [2:0] A_STAT    = 3'd5;

    localparam logic [3:0] IID_RDA  = 4'b0100;
    localparam logic [3:0] IID_NONE = 4'b0001;

    // Trigger level in bytes for a select code and queue width.
    function automatic int unsigned trig_bytes(input logic [1:0] sel, input logic wide);
        case (sel)
            2'd0:    trig_bytes = 1;
            2'd1:    trig_bytes = wide ? 16 : 4;
            2'd2:    trig_bytes = wide ? 32 : 8;
            default: trig_bytes = wide ? 56 : 14;
        endcase
    endfunction
endpackage

// File: rtl/ufc_fcr_ctl.sv
// Control decoder: holds the enable, width and trigger-select state plus
// the line control byte. Produces a combinational receive-flush and a
// registered one-cycle transmit-clear pulse.
// Assumes the width bit is only accepted while the line control byte is 0.
module ufc_fcr_ctl
    import ufc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_fcr,
    input  logic       wr_lcr,
    input  logic [7:0] wdata,
    output logic       fifo_en,
    output logic       wide,
    output logic [1:0] trig_sel,
    output logic [7:0] lcr,
    output logic       rx_flush,
    output logic       tx_flush
);
    logic en_nxt;
    logic wide_nxt;
    logic mode_chg;

    // Next mode from the written byte; width is locked while LCR is nonzero.
    always_comb begin
        en_nxt   = wdata[FCR_EN];
        wide_nxt = en_nxt & ((lcr == 8'd0) ? wdata[FCR_WIDE] : wide);
        mode_chg = wr_fcr && ((en_nxt != fifo_en) || (wide_nxt != wide));
        rx_flush = (wr_fcr && wdata[FCR_RXCLR]) || mode_chg;
    end

    // Mode, trigger and line control registers, plus the transmit-clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en  <= 1'b0;
            wide     <= 1'b0;
            trig_sel <= 2'd0;
            lcr      <= 8'd0;
            tx_flush <= 1'b0;
        end else begin
            tx_flush <= (wr_fcr && wdata[FCR_TXCLR]) || mode_chg;
            if (wr_fcr) begin
                fifo_en  <= en_nxt;
                wide     <= wide_nxt;
                trig_sel <= wdata[FCR_TRIG+1:FCR_TRIG];
            end
            if (wr_lcr) lcr <= wdata;
        end
    end

    // R4: wide mode never exists without the FIFOs enabled.
    a_r4_wide_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        wide |-> fifo_en);
    // R11: toggling the enable bit produces a transmit-clear pulse next cycle.
    a_r11_toggle_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fcr && (wdata[FCR_EN] != fifo_en)) |=> tx_flush);
endmodule

// File: rtl/ufc_rx_fifo.sv
// Receive queue: circular buffer of MAX_DEPTH entries whose usable depth is
// limited at run time by depth_lim. Flush wins over push and pop in the same
// cycle. Reports a one-cycle overflow strobe for a dropped push.
// Assumes MAX_DEPTH is a power of two and depth_lim <= MAX_DEPTH.
module ufc_rx_fifo #(
    parameter int DW        = 8,
    parameter int MAX_DEPTH = 64,
    localparam int PW = $clog2(MAX_DEPTH),
    localparam int CW = $clog2(MAX_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] depth_lim,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          ovf
);
    logic [DW-1:0] mem [MAX_DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic          full;
    logic          do_pop;
    logic          do_push;

    // Accept/reject decisions for this cycle.
    always_comb begin
        full    = count >= depth_lim;
        do_pop  = pop && (count != '0) && !flush;
        do_push = push && !flush && (!full || do_pop);
        ovf     = push && !flush && full && !do_pop;
        head    = mem[rd_ptr];
    end

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + PW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + PW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // R10: a flush leaves the queue empty.
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
    // R9: a dropped push leaves the fill level where it was.
    a_r9_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (count == $past(count)));
    // R12: a pop on an empty queue does not move the level.
    a_r12_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && count == '0) |=> (count == '0));
endmodule

// File: rtl/ufc_rx_trig.sv
// Trigger compare: picks the byte threshold from mode and select code and
// raises the interrupt while the fill level is at or above it.
// Assumes a one-byte threshold whenever the FIFOs are off.
module ufc_rx_trig
    import ufc_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic [CW-1:0] count,
    input  logic          fifo_en,
    input  logic          wide,
    input  logic [1:0]    sel,
    output logic          irq
);
    logic [CW-1:0] level;

    // Threshold selection and comparison.
    always_comb begin
        level = fifo_en ? CW'(trig_bytes(sel, wide)) : CW'(1);
        irq   = count >= level;
    end
endmodule

// File: rtl/uart_fifo_ctl.sv
// Top of the UART FIFO control block: register decode, sticky overrun flag,
// read mux and identification byte. Queue depth is 1 with FIFOs off,
// STD_DEPTH normally and MAX_DEPTH in wide mode.
// Assumes MAX_DEPTH is a power of two and at least 56.
module uart_fifo_ctl
    import ufc_pkg::*;
#(
    parameter int MAX_DEPTH = 64,
    parameter int STD_DEPTH = 16,
    localparam int CW = $clog2(MAX_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          rx_push,
    input  logic [7:0]    rx_byte,
    input  logic          host_pop,
    output logic [7:0]    host_byte,
    output logic [CW-1:0] rx_level,
    output logic          rx_irq,
    output logic          tx_clear
);
    localparam logic [CW-1:0] DEPTH_MAX = CW'(MAX_DEPTH);
    localparam logic [CW-1:0] DEPTH_STD = CW'(STD_DEPTH);

    logic          wr_fcr;
    logic          wr_lcr;
    logic          fifo_en;
    logic          wide;
    logic [1:0]    trig_sel;
    logic [7:0]    lcr;
    logic          rx_flush;
    logic          ovf;
    logic          overrun;
    logic [CW-1:0] depth_lim;
    logic [7:0]    iir;

    // Write decode and run-time depth limit.
    always_comb begin
        wr_fcr    = reg_wr && (reg_addr == A_FCR_IIR);
        wr_lcr    = reg_wr && (reg_addr == A_LCR);
        depth_lim = !fifo_en ? CW'(1) : (wide ? DEPTH_MAX : DEPTH_STD);
    end

    ufc_fcr_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_fcr   (wr_fcr),
        .wr_lcr   (wr_lcr),
        .wdata    (reg_wdata),
        .fifo_en  (fifo_en),
        .wide     (wide),
        .trig_sel (trig_sel),
        .lcr      (lcr),
        .rx_flush (rx_flush),
        .tx_flush (tx_clear)
    );

    ufc_rx_fifo #(.DW(8), .MAX_DEPTH(MAX_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .depth_lim (depth_lim),
        .push      (rx_push),
        .push_data (rx_byte),
        .pop       (host_pop),
        .head      (host_byte),
        .count     (rx_level),
        .ovf       (ovf)
    );

    ufc_rx_trig #(.CW(CW)) u_trig (
        .count   (rx_level),
        .fifo_en (fifo_en),
        .wide    (wide),
        .sel     (trig_sel),
        .irq     (rx_irq)
    );

    // Sticky overrun: a new drop wins over a clearing status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  overrun <= 1'b0;
        else if (ovf)                                overrun <= 1'b1;
        else if (reg_rd && (reg_addr == A_STAT))     overrun <= 1'b0;
    end

    // Identification byte and read data mux.
    always_comb begin
        iir = {fifo_en, fifo_en, wide, 1'b0, rx_irq ? IID_RDA : IID_NONE};
        case (reg_addr)
            A_FCR_IIR: reg_rdata = iir;
            A_LCR:     reg_rdata = lcr;
            A_STAT:    reg_rdata = {6'd0, overrun, rx_level != '0};
            default:   reg_rdata = 8'd0;
        endcase
    end

    // R3: wide mode shows 111 in the top identification bits.
    a_r3_wide_iir: assert property (@(posedge clk) disable iff (!rst_n)
        wide |-> (iir[7:5] == 3'b111));
    // R7: the interrupt implies a non-empty queue.
    a_r7_irq_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_level != '0));
    // R9: a dropped push is always visible as overrun on the next cycle.
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> overrun);
endmodule

// File: tb/uart_fifo_ctl_test.sv
`timescale 1ns/1ps
module uart_fifo_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd2;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       rx_push = 1'b0, host_pop = 1'b0;
    logic [7:0] rx_byte = 8'd0;
    logic [7:0] host_byte;
    logic [6:0] rx_level;
    logic       rx_irq, tx_clear;

    int    n_run = 0, n_fail = 0;
    string ctx = "R1";
    bit    done = 1'b0;

    // Reference model state.
    byte unsigned mq[$];
    bit        m_en, m_wide, m_ovr, m_txf;
    bit [1:0]  m_sel;
    bit [7:0]  m_lcr;

    uart_fifo_ctl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_push(rx_push), .rx_byte(rx_byte), .host_pop(host_pop),
        .host_byte(host_byte), .rx_level(rx_level), .rx_irq(rx_irq),
        .tx_clear(tx_clear)
    );

    always #4 clk = ~clk;

    function automatic int exp_depth();
        return !m_en ? 1 : (m_wide ? 64 : 16);
    endfunction

    function automatic int exp_trig();
        int t[4];
        if (!m_en) return 1;
        t = m_wide ? '{1, 16, 32, 56} : '{1, 4, 8, 14};
        return t[m_sel];
    endfunction

    function automatic bit exp_irq();
        return mq.size() >= exp_trig();
    endfunction

    task automatic chk(string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", ctx, what, act, exp);
        end
    endtask

    // Compare every output with the model for the inputs now applied.
    task automatic check_now();
        int rd_exp;
        chk("level", rx_level, mq.size());
        chk("irq (R7)", rx_irq, exp_irq());
        chk("tx_clear (R10)", tx_clear, m_txf);
        if (mq.size() != 0) chk("head (R12)", host_byte, mq[0]);
        case (reg_addr)
            3'd2: rd_exp = {m_en, m_en, m_wide, 1'b0, exp_irq() ? 4'b0100 : 4'b0001};
            3'd3: rd_exp = m_lcr;
            3'd5: rd_exp = {6'd0, m_ovr, mq.size() != 0};
            default: rd_exp = 0;
        endcase
        chk("rdata", reg_rdata, rd_exp);
    endtask

    // Advance the model over one rising edge with the applied inputs.
    task automatic model_edge();
        bit fcr = reg_wr && reg_addr == 3'd2;
        bit n_en = reg_wdata[0];
        bit n_wide = n_en & ((m_lcr == 0) ? reg_wdata[5] : m_wide);
        bit chg = fcr && (n_en != m_en || n_wide != m_wide);
        bit flush = (fcr && reg_wdata[1]) || chg;
        bit popped;
        bit ovf = 1'b0;
        if (flush) mq.delete();
        else begin
            popped = host_pop && mq.size() != 0;
            if (rx_push && mq.size() >= exp_depth() && !popped) ovf = 1'b1;
            if (popped) void'(mq.pop_front());
            if (rx_push && !ovf) mq.push_back(rx_byte);
        end
        if (ovf) m_ovr = 1'b1;
        else if (reg_rd && reg_addr == 3'd5) m_ovr = 1'b0;
        m_txf = (fcr && reg_wdata[2]) || chg;
        if (fcr) begin
            m_en = n_en; m_wide = n_wide; m_sel = reg_wdata[7:6];
        end
        if (reg_wr && reg_addr == 3'd3) m_lcr = reg_wdata;
    endtask

    task automatic step(bit w, bit [2:0] a, bit [7:0] d, bit rd, bit ps, bit pp);
        reg_wr = w; reg_addr = a; reg_wdata = d; reg_rd = rd;
        rx_push = ps; rx_byte = 8'($urandom); host_pop = pp;
        #1 check_now();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic fcr(bit [7:0] d);  step(1, 3'd2, d, 0, 0, 0); endtask
    task automatic lcrw(bit [7:0] d); step(1, 3'd3, d, 0, 0, 0); endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 3'd2, 0, 0, 0, 0);
    endtask
    task automatic pushes(int n);
        for (int i = 0; i < n; i++) step(0, 3'd2, 0, 0, 1, 0);
    endtask
    task automatic pops(int n);
        for (int i = 0; i < n; i++) step(0, 3'd2, 0, 0, 0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, then line control readback.
        ctx = "R1"; idle(1);
        step(0, 3'd3, 0, 0, 0, 0);
        // R2: 16-entry mode.
        ctx = "R2"; fcr(8'h01); idle(1);
        // R9: fill past 16, drop and sticky flag, clear by read.
        ctx = "R9"; pushes(18);
        step(0, 3'd5, 0, 1, 0, 0);
        step(0, 3'd5, 0, 0, 0, 0);
        // R12: push and pop together on a full queue, then drain past empty.
        ctx = "R12"; step(0, 3'd2, 0, 0, 1, 1); pops(18);
        // R5: each standard trigger level.
        ctx = "R5";
        for (int s = 0; s < 4; s++) begin
            fcr({2'(s), 6'b000011}); pushes(15); pops(15);
        end
        // R3 and R6: wide mode and its trigger levels.
        ctx = "R3"; fcr(8'h21); idle(1);
        ctx = "R6";
        for (int s = 0; s < 4; s++) begin
            fcr({2'(s), 6'b100011}); pushes(58); pops(3);
        end
        ctx = "R9"; pushes(8); step(1, 3'd5, 0, 1, 1, 0); idle(1);
        // R4: width locked while line control is nonzero; disable clears it.
        ctx = "R4"; lcrw(8'h03); fcr(8'h01); idle(1);
        fcr(8'h00); fcr(8'h21); idle(1); lcrw(8'h00);
        // R8: FIFOs off hold one byte.
        ctx = "R8"; fcr(8'h00); pushes(3); pops(2);
        // R10: clear bits act once and are not stored.
        ctx = "R10"; fcr(8'h01); pushes(5); fcr(8'h05); idle(1);
        fcr(8'h03); pushes(3); fcr(8'h01); idle(2);
        // R11: width change empties queue and pulses tx_clear.
        ctx = "R11"; pushes(4); fcr(8'h21); idle(1); pushes(4); fcr(8'h01); idle(1);
        // R12: random mix of traffic and control writes.
        ctx = "R12";
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            if (r < 3)      fcr((8'($urandom) & 8'hE7) | ((r == 0) ? 8'h00 : 8'h01));
            else if (r < 4) lcrw(($urandom_range(0, 1) == 1) ? 8'h03 : 8'h00);
            else step(0, 3'($urandom_range(2, 5)), 0, $urandom_range(0, 9) == 0,
                      $urandom_range(0, 1) == 1, $urandom_range(0, 9) < 4);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule